// File: doc/BRIEF.md
# Audio Zero-Run Auto-Mute Detector

This block monitors a stereo PCM stream one frame at a time and raises a mute request for the left and for the right output. A request rises once a channel has carried only zero samples for a programmable number of frames. Each channel picks its run length from a 3-bit code that indexes a fixed, nonlinear table of frame counts.

A mode input selects one of two behaviours. In independent mode each channel is judged on its own samples. In linked mode a frame counts as silent only when both samples are zero, both requests use the larger of the two thresholds, and both rise and fall together. A per-channel enable turns detection off for that channel.

A hardware-default input replaces every setting with its reset value. Any change to the effective settings restarts the affected counts from zero. The counters saturate, so a silence of any length keeps the mute asserted.

Top module: `zero_run_mute`

## Requirements
- R1: While rst_ni is low, and after it is released with no frame yet received, mute_l_o and mute_r_o are 0 and both run counts are zero.
- R2: A run count advances only on cycles where frame_i is 1. A mute flag goes high in the cycle after the frame strobe at which the consecutive-zero count reaches the channel's threshold. A sample counts as zero only when every bit of the word is 0.
- R3: Threshold codes map to frame counts as follows: 0→1024, 1→5120, 2→10240, 3→25600, 4→51200, 5→102400, 6→256000, 7→512000.
- R4: With link_i = 0, each channel counts and mutes on its own samples against its own threshold code, and the other channel has no effect on it.
- R5: With link_i = 1, a frame counts only if both samples are zero. A nonzero sample on either channel clears both counts. Both enabled flags rise together, at the larger of the two thresholds.
- R6: While a channel's enable is 0, its count is held at zero and its mute flag stays 0.
- R7: A frame carrying a nonzero sample that the channel observes clears that channel's count and drops its mute flag in the cycle after that frame.
- R8: A mute flag stays high for as long as zero frames continue. The count saturates at its maximum and never wraps.
- R9: A change of the effective mode clears both channels. A change of a channel's enable or threshold code clears that channel, or both channels when linked mode is active. The clear takes effect at the next clock edge, whether or not a frame strobe is present.
- R10: While hw_dflt_i is 1, the programmed inputs are ignored. The block behaves as linked mode, with both channels enabled and both threshold codes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe, one per stereo frame |
| left_i | input | DATA_W | Left sample word |
| right_i | input | DATA_W | Right sample word |
| link_i | input | 1 | 1 = linked mode, 0 = independent mode |
| en_l_i | input | 1 | Left detection enable |
| en_r_i | input | 1 | Right detection enable |
| code_l_i | input | 3 | Left threshold code |
| code_r_i | input | 3 | Right threshold code |
| hw_dflt_i | input | 1 | Force default settings |
| mute_l_o | output | 1 | Left mute request |
| mute_r_o | output | 1 | Right mute request |

## Verification
The bench drives silences ending one frame short of the threshold and silences that reach it exactly. This separates an off-by-one in the compare from a correct count. Strobes spaced one cycle apart show that frames are counted, not clock cycles.

Zero runs on one channel with noise on the other tell the independent and linked modes apart. Unequal codes in linked mode show that the larger threshold governs.

Mid-run changes to the code, the enable, the mode and the hardware-default input check that only the intended channels restart.

// File: rtl/zrm_pkg.sv
package zrm_pkg;
  localparam int THR_W = 19;

  typedef struct packed {
    logic       link;
    logic       en_l;
    logic       en_r;
    logic [2:0] code_l;
    logic [2:0] code_r;
  } zrm_cfg_t;

  localparam zrm_cfg_t CFG_DEFAULT = '{link: 1'b1, en_l: 1'b1, en_r: 1'b1,
                                       code_l: 3'd0, code_r: 3'd0};

  function automatic logic [THR_W-1:0] thr_frames(input logic [2:0] code);
    case (code)
      3'd0:    thr_frames = 19'd1024;
      3'd1:    thr_frames = 19'd5120;
      3'd2:    thr_frames = 19'd10240;
      3'd3:    thr_frames = 19'd25600;
      3'd4:    thr_frames = 19'd51200;
      3'd5:    thr_frames = 19'd102400;
      3'd6:    thr_frames = 19'd256000;
      default: thr_frames = 19'd512000;
    endcase
  endfunction
endpackage

// File: rtl/zrm_cfg.sv
module zrm_cfg
  import zrm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hw_dflt_i,
  input  zrm_cfg_t prog_i,
  output zrm_cfg_t cfg_o,
  output logic     clr_l_o,
  output logic     clr_r_o
);
  zrm_cfg_t prev_q;
  logic     mode_chg, chg_l, chg_r;

  assign cfg_o    = hw_dflt_i ? CFG_DEFAULT : prog_i;
  assign mode_chg = cfg_o.link != prev_q.link;
  assign chg_l    = (cfg_o.en_l != prev_q.en_l) || (cfg_o.code_l != prev_q.code_l);
  assign chg_r    = (cfg_o.en_r != prev_q.en_r) || (cfg_o.code_r != prev_q.code_r);
  // linked mode: a change to either side restarts both
  assign clr_l_o  = mode_chg || chg_l || (cfg_o.link && chg_r);
  assign clr_r_o  = mode_chg || chg_r || (cfg_o.link && chg_l);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= CFG_DEFAULT;
    else         prev_q <= cfg_o;
  end

  AST_HW_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_dflt_i && $past(hw_dflt_i) |-> !clr_l_o && !clr_r_o); // R10
endmodule

// File: rtl/zrm_chan.sv
module zrm_chan #(
  parameter int CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             frame_i,
  input  logic             en_i,
  input  logic             zero_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             mute_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_inc;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mute_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      mute_o <= 1'b0;
    end else if (frame_i) begin
      if (!en_i || !zero_i) begin
        cnt_q  <= '0;
        mute_o <= 1'b0;
      end else begin
        cnt_q  <= cnt_inc;
        mute_o <= cnt_inc >= thr_i;
      end
    end
  end

  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !mute_o && cnt_q == '0); // R9
  AST_NZ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && !zero_i |=> !mute_o); // R7
  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && (frame_i || clr_i) |=> !mute_o && cnt_q == '0); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i && !clr_i |=> $stable(cnt_q) && $stable(mute_o)); // R2
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && zero_i && en_i && !clr_i && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX); // R8
  AST_RISE_ON_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mute_o) |-> $past(frame_i && zero_i && en_i)); // R2
endmodule

// File: rtl/zero_run_mute.sv
module zero_run_mute
  import zrm_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic              link_i,
  input  logic              en_l_i,
  input  logic              en_r_i,
  input  logic [2:0]        code_l_i,
  input  logic [2:0]        code_r_i,
  input  logic              hw_dflt_i,
  output logic              mute_l_o,
  output logic              mute_r_o
);
  localparam int NCH = 2;

  zrm_cfg_t         prog, cfg;
  logic [NCH-1:0]   clr, en, zero_raw, zero_sel, mute;
  logic [THR_W-1:0] thr_raw [NCH];
  logic [THR_W-1:0] thr_max;

  assign prog = '{link: link_i, en_l: en_l_i, en_r: en_r_i,
                  code_l: code_l_i, code_r: code_r_i};

  zrm_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_dflt_i (hw_dflt_i),
    .prog_i    (prog),
    .cfg_o     (cfg),
    .clr_l_o   (clr[0]),
    .clr_r_o   (clr[1])
  );

  assign zero_raw[0] = left_i == '0;
  assign zero_raw[1] = right_i == '0;
  assign en          = {cfg.en_r, cfg.en_l};
  assign thr_raw[0]  = thr_frames(cfg.code_l);
  assign thr_raw[1]  = thr_frames(cfg.code_r);
  assign thr_max     = (thr_raw[0] > thr_raw[1]) ? thr_raw[0] : thr_raw[1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [THR_W-1:0] thr_sel;
    assign zero_sel[g] = cfg.link ? &zero_raw : zero_raw[g];
    assign thr_sel     = cfg.link ? thr_max : thr_raw[g];

    zrm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr[g]),
      .frame_i (frame_i),
      .en_i    (en[g]),
      .zero_i  (zero_sel[g]),
      .thr_i   (CNT_W'(thr_sel)),
      .mute_o  (mute[g])
    );
  end

  assign mute_l_o = mute[0];
  assign mute_r_o = mute[1];

  AST_LINK_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.link && &en && $past(cfg.link && &en) |-> mute_l_o == mute_r_o); // R5
  AST_INDEP_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.link && !clr[0] && frame_i && zero_raw[0] && mute_l_o |=> mute_l_o); // R4
endmodule

// File: tb/zero_run_mute_tb.sv
module zero_run_mute_tb_top;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          frame = 1'b0, link = 1'b1, en_l = 1'b1, en_r = 1'b1, hw = 1'b0;
  logic [DW-1:0] left = '0, right = '0;
  logic [2:0]    code_l = 3'd0, code_r = 3'd0;
  logic          mute_l, mute_r;

  int    n_chk = 0, n_fail = 0, cycles = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  zero_run_mute #(.DATA_W(DW), .CNT_W(19)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame), .left_i(left), .right_i(right),
    .link_i(link), .en_l_i(en_l), .en_r_i(en_r), .code_l_i(code_l), .code_r_i(code_r),
    .hw_dflt_i(hw), .mute_l_o(mute_l), .mute_r_o(mute_r));

  // behavioural reference
  int  m_cl, m_cr;
  bit  m_ml, m_mr;
  bit  p_link, p_el, p_er;
  int  p_tl, p_tr;

  function automatic int tab(input int c);
    int t [8] = '{1024, 5120, 10240, 25600, 51200, 102400, 256000, 512000};
    return t[c];
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cl = 0; m_cr = 0; m_ml = 0; m_mr = 0;
      p_link = 1; p_el = 1; p_er = 1; p_tl = 0; p_tr = 0;
    end else begin
      bit e_link, e_el, e_er, cm, cl_, cr_, clrl, clrr, zl, zr;
      int e_tl, e_tr, tl, tr, tm;
      e_link = hw ? 1'b1 : link;
      e_el   = hw ? 1'b1 : en_l;
      e_er   = hw ? 1'b1 : en_r;
      e_tl   = hw ? 0 : int'(code_l);
      e_tr   = hw ? 0 : int'(code_r);
      cm   = e_link != p_link;
      cl_  = (e_el != p_el) || (e_tl != p_tl);
      cr_  = (e_er != p_er) || (e_tr != p_tr);
      clrl = cm || cl_ || (e_link && cr_);
      clrr = cm || cr_ || (e_link && cl_);
      tm   = tab(e_tl) > tab(e_tr) ? tab(e_tl) : tab(e_tr);
      zl   = e_link ? (left == 0 && right == 0) : (left == 0);
      zr   = e_link ? (left == 0 && right == 0) : (right == 0);
      tl   = e_link ? tm : tab(e_tl);
      tr   = e_link ? tm : tab(e_tr);
      if (clrl) begin m_cl = 0; m_ml = 0; end
      else if (frame) begin
        if (!e_el || !zl) begin m_cl = 0; m_ml = 0; end
        else begin m_cl = (m_cl < 524287) ? m_cl + 1 : m_cl; m_ml = m_cl >= tl; end
      end
      if (clrr) begin m_cr = 0; m_mr = 0; end
      else if (frame) begin
        if (!e_er || !zr) begin m_cr = 0; m_mr = 0; end
        else begin m_cr = (m_cr < 524287) ? m_cr + 1 : m_cr; m_mr = m_cr >= tr; end
      end
      p_link = e_link; p_el = e_el; p_er = e_er; p_tl = e_tl; p_tr = e_tr;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk({phase, " model left"},  mute_l, m_ml);
    chk({phase, " model right"}, mute_r, m_mr);
    if (cycles > 190000) begin
      n_fail++;
      $display("FAIL watchdog expired in %s", phase);
      $display("  %0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
    end
  end

  task automatic frames(input int n, input logic [DW-1:0] l, input logic [DW-1:0] r,
                        input bit gap = 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame = 1'b1; left = l; right = r;
      if (gap) begin @(negedge clk); frame = 1'b0; end
    end
    @(negedge clk); frame = 1'b0;
  endtask

  task automatic idle(input int n = 1);
    for (int i = 0; i < n; i++) begin @(negedge clk); frame = 1'b0; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset left", mute_l, 1'b0);
    chk("R1 reset right", mute_r, 1'b0);
    rst_ni = 1'b1;
    idle(2);
    chk("R1 after release", mute_l | mute_r, 1'b0);

    // defaults: linked, code 0 -> 1024 frames
    phase = "R3";
    frames(1023, '0, '0);
    chk("R3 1023 frames no mute", mute_l | mute_r, 1'b0);
    idle(5);
    chk("R2 idle cycles do not count", mute_l, 1'b0);
    frames(1, '0, '0);
    chk("R3 1024 frames left", mute_l, 1'b1);
    chk("R5 1024 frames right together", mute_r, 1'b1);
    phase = "R8";
    frames(2000, '0, '0);
    chk("R8 held through silence", mute_l & mute_r, 1'b1);
    phase = "R5";
    frames(1, 24'h000001, '0);
    chk("R5 left noise drops right", mute_r, 1'b0);
    chk("R7 noise drops left", mute_l, 1'b0);

    // independent, left code 0, right code 1, strobes every other cycle
    phase = "R4";
    link = 1'b0; code_r = 3'd1;
    idle(2);
    frames(1024, '0, 24'h800000, 1);
    chk("R4 left mutes alone", mute_l, 1'b1);
    chk("R4 right noisy stays open", mute_r, 1'b0);
    frames(5119, '0, '0);
    chk("R3 code1 at 5119", mute_r, 1'b0);
    frames(1, '0, '0);
    chk("R3 code1 at 5120", mute_r, 1'b1);
    frames(1, '0, 24'h000100);
    chk("R7 right noise drops right", mute_r, 1'b0);
    chk("R4 left unaffected", mute_l, 1'b1);

    // config change clears only that channel
    phase = "R9";
    code_r = 3'd0;
    idle(2);
    chk("R9 left kept on right code change", mute_l, 1'b1);
    code_l = 3'd1;
    idle(2);
    chk("R9 left cleared by code change", mute_l, 1'b0);

    // enable off
    phase = "R6";
    code_l = 3'd0; en_r = 1'b0;
    frames(1500, '0, '0);
    chk("R6 disabled right quiet", mute_r, 1'b0);
    chk("R6 left still works", mute_l, 1'b1);
    en_r = 1'b1;

    // linked, larger threshold rules
    phase = "R5";
    link = 1'b1; code_l = 3'd2; code_r = 3'd0;
    idle(2);
    chk("R9 mode change clears", mute_l | mute_r, 1'b0);
    frames(3000, '0, 24'h000002);
    chk("R5 one noisy side blocks", mute_l | mute_r, 1'b0);
    frames(10239, '0, '0);
    chk("R5 below larger threshold", mute_l | mute_r, 1'b0);
    frames(1, '0, '0);
    chk("R5 at larger threshold", mute_l & mute_r, 1'b1);

    // hardware default overrides programmed values
    phase = "R10";
    link = 1'b0; code_l = 3'd7; code_r = 3'd7; en_l = 1'b0; hw = 1'b1;
    idle(2);
    frames(1024, '0, '0);
    chk("R10 default linked 1024 left", mute_l, 1'b1);
    chk("R10 default linked 1024 right", mute_r, 1'b1);
    frames(1, '0, 24'h000004);
    chk("R10 linked release", mute_l, 1'b0);
    idle(3);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule